// File: doc/BRIEF.md
# Clock-Switch Start-Up Delay Controller

This block keeps the processor in a wait state after a wake-up, a power-on reset or a change of system clock source. It releases execution only after the right stabilization wait has passed. The wait comes in one of two kinds. The first is a fixed interval that lets the memory bias settle. It is timed by counting `FIX_TICKS` pulses of a free-running reference tick, for example 80 pulses of an 8 MHz reference for 10 µs. The second is an oscillator start-up wait of `OST_CYCLES` (1024) cycles of the newly selected oscillator.

A one-cycle `start` pulse captures the target clock source and the state the system is leaving. The block uses that pair to pick the wait kind and then raises `busy`. When the wait ends, `busy` falls and `ready` rises. Both timing inputs are single-cycle enables that are already synchronous to `clk`. `osc_tick` marks one cycle of the target oscillator. Any pair that no rule covers falls back to the 1024-cycle wait.

Top module: `clkswitch_delay`

## Requirements
- R1: A synchronous `rst` sets `busy`=1 and `ready`=0. It selects the wait kind from `src_sel`, with power-on taken as the previous state, so power-up always passes through a wait.
- R2: The crystal targets are `src_sel` 2 (XT), 3 (HS) and 4 (low-power 32 kHz). When the previous state is sleep (`from_state`=0) or the high-frequency internal oscillator (`from_state`=2), these targets wait for `OST_CYCLES` pulses of `osc_tick`.
- R3: The internal oscillator targets are `src_sel` 0 (31 kHz) and 1 (high-frequency). When the previous state is sleep (0) or power-on (1), these targets wait for `FIX_TICKS` pulses of `ref_tick`.
- R4: The external clock and RC targets are `src_sel` 5 and 6. When the previous state is sleep (0), power-on (1) or the 31 kHz internal oscillator (3), these targets wait for `FIX_TICKS` pulses of `ref_tick`.
- R5: Every other pair waits for `OST_CYCLES` pulses of `osc_tick`. This covers `src_sel` 7, crystals from power-on or from 31 kHz, internal targets from an internal oscillator, and external targets from the high-frequency internal oscillator.
- R6: `busy` falls one clock after the edge that counts the final pulse, and `ready` is always the complement of `busy`. With a pulse on every cycle, `busy` stays high for the limit plus 1 edges after the edge that captures `start`.
- R7: During a fixed wait, `osc_tick` has no effect. During an oscillator wait, `ref_tick` has no effect.
- R8: A `start` pulse, even one that arrives while busy, clears the count and reselects the wait kind from the inputs presented with it. Any pulse of the timing input that comes in the same cycle as `start` is not counted.
- R9: Once the block is ready, both timing inputs are ignored and `ready` stays high until the next `start` or `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a wait |
| src_sel | input | 3 | Target source: 0 LF internal, 1 HF internal, 2 XT, 3 HS, 4 LP crystal, 5 external clock, 6 RC, 7 reserved |
| from_state | input | 2 | Previous state: 0 sleep, 1 power-on, 2 HF internal oscillator, 3 LF internal oscillator |
| ref_tick | input | 1 | Reference pulse that times the fixed wait |
| osc_tick | input | 1 | Pulse marking one cycle of the target oscillator |
| ready | output | 1 | Execution may proceed |
| busy | output | 1 | Wait in progress |

## Verification
Every result of this block is due one edge after its cause. A `start` or `rst` shows up as `busy` on the next edge. Each counted pulse advances the count on the edge that samples it. The release comes on the edge after the count reaches the limit, so a run with a pulse every cycle ends the limit plus 1 edges after the capture edge. The bench drives inputs on the falling edge and updates its own remaining-pulse model on the rising edge. It compares `busy` and `ready` on the falling edge in between, and it also counts falling edges from `start` to `ready` to check the exact latencies.

// File: rtl/clkswitch_delay.sv
module clkswitch_delay #(
  parameter int FIX_TICKS  = 80,
  parameter int OST_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [2:0] src_sel,
  input  logic [1:0] from_state,
  input  logic       ref_tick,
  input  logic       osc_tick,
  output logic       ready,
  output logic       busy
);
  localparam int MAXC = (OST_CYCLES > FIX_TICKS) ? OST_CYCLES : FIX_TICKS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] FIX_LIM = CW'(FIX_TICKS);
  localparam logic [CW-1:0] OST_LIM = CW'(OST_CYCLES);

  localparam logic [1:0] FROM_SLEEP = 2'd0;
  localparam logic [1:0] FROM_POR   = 2'd1;
  localparam logic [1:0] FROM_HFINT = 2'd2;

  function automatic logic pick_ost(input logic [2:0] s, input logic [1:0] f);
    case (s)
      3'd0, 3'd1: pick_ost = !(f == FROM_SLEEP || f == FROM_POR);
      3'd5, 3'd6: pick_ost = (f == FROM_HFINT);
      default:    pick_ost = 1'b1;
    endcase
  endfunction

  logic          use_ost;
  logic [CW-1:0] cnt;
  logic          sel_ost;
  logic          tick;
  logic [CW-1:0] lim;

  assign sel_ost = pick_ost(src_sel, rst ? FROM_POR : from_state);
  assign tick    = use_ost ? osc_tick : ref_tick;
  assign lim     = use_ost ? OST_LIM : FIX_LIM;
  assign ready   = ~busy;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      busy    <= 1'b1;
      cnt     <= '0;
      use_ost <= sel_ost;
    end else if (busy) begin
      if (cnt == lim)
        busy <= 1'b0;
      else if (tick)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkswitch_delay_chk.sv
module clkswitch_delay_chk #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          ref_tick,
  input logic          osc_tick,
  input logic          busy,
  input logic          use_ost,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lim
);
  p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && cnt == '0);

  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    busy && !start && cnt == lim |=> !busy);

  p_hold_ready_r9: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> !busy && $stable(cnt));

  p_ost_ignores_ref_r7: assert property (@(posedge clk) disable iff (rst)
    busy && !start && use_ost && !osc_tick |=> $stable(cnt));

  p_fix_ignores_osc_r7: assert property (@(posedge clk) disable iff (rst)
    busy && !start && !use_ost && !ref_tick |=> $stable(cnt));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt <= lim);
endmodule

bind clkswitch_delay clkswitch_delay_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .ref_tick(ref_tick),
  .osc_tick(osc_tick), .busy(busy), .use_ost(use_ost), .cnt(cnt), .lim(lim)
);

// File: tb/clkswitch_delay_test.sv
module clkswitch_delay_test;
  localparam int FIX = 80;
  localparam int OST = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] src_sel = 3'd2;
  logic [1:0] from_state = 2'd0;
  logic ref_tick = 1'b0;
  logic osc_tick = 1'b0;
  logic ready, busy;

  int total = 0;
  int bad = 0;
  string phase = "R1";
  int ref_per = 1;
  int osc_per = 0;
  int rc = 0;
  int oc = 0;

  bit m_busy = 1'b1;
  bit m_ost = 1'b1;
  int m_left = OST;

  always #5 clk = ~clk;

  clkswitch_delay #(.FIX_TICKS(FIX), .OST_CYCLES(OST)) uut (
    .clk(clk), .rst(rst), .start(start), .src_sel(src_sel),
    .from_state(from_state), .ref_tick(ref_tick), .osc_tick(osc_tick),
    .ready(ready), .busy(busy)
  );

  function automatic bit rule_ost(int s, int f);
    if (s >= 2 && s <= 4) return 1'b1;
    if (s <= 1) return (f >= 2);
    if (s == 5 || s == 6) return (f == 2);
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst || start) begin
      m_busy = 1'b1;
      m_ost  = rule_ost(int'(src_sel), rst ? 1 : int'(from_state));
      m_left = m_ost ? OST : FIX;
    end else if (m_busy) begin
      if (m_left == 0) m_busy = 1'b0;
      else if (m_ost ? osc_tick : ref_tick) m_left--;
    end
  end

  always @(negedge clk) begin
    rc++; oc++;
    ref_tick <= (ref_per > 0) && (rc % ref_per == 0);
    osc_tick <= (osc_per > 0) && (oc % osc_per == 0);
    total++;
    if (busy !== m_busy || ready !== !m_busy) begin
      bad++;
      $display("FAIL %s per-cycle busy=%0b ready=%0b expected busy=%0b", phase, busy, ready, m_busy);
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic kick(int s, int f);
    @(negedge clk);
    src_sel = 3'(s); from_state = 2'(f); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_ready(string req, int maxc, output int n);
    n = 0;
    while (busy === 1'b1 && n < maxc) begin
      @(negedge clk);
      n++;
    end
    check(req, int'(ready), 1);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 busy after reset", int'(busy), 1);
    check("R1 ready after reset", int'(ready), 0);
    phase = "R7";
    repeat (300) @(negedge clk);
    check("R7 ref ticks ignored in oscillator wait", int'(busy), 1);
    osc_per = 1;
    wait_ready("R1 power-on wait ends", 1200, n);

    phase = "R2";
    osc_per = 2;
    kick(3, 0);
    wait_ready("R2 HS from sleep", 2300, n);
    osc_per = 1;
    kick(4, 2);
    wait_ready("R2 LP from internal", 1200, n);
    check("R2 LP latency", n, OST + 1);

    phase = "R3";
    ref_per = 3;
    kick(0, 1);
    wait_ready("R3 LF internal from power-on", 400, n);
    ref_per = 1;
    kick(1, 0);
    wait_ready("R3 HF internal from sleep", 200, n);
    check("R3 latency", n, FIX + 1);

    phase = "R4";
    osc_per = 0;
    kick(5, 3);
    wait_ready("R4 external from LF internal", 200, n);
    check("R4 latency", n, FIX + 1);
    kick(6, 0);
    wait_ready("R4 RC from sleep", 200, n);

    phase = "R5";
    osc_per = 1; ref_per = 1;
    kick(1, 2);
    wait_ready("R5 internal from internal", 1200, n);
    check("R5 default latency", n, OST + 1);
    kick(7, 0);
    wait_ready("R5 reserved source", 1200, n);
    kick(2, 1);
    wait_ready("R5 crystal from power-on", 1200, n);

    phase = "R6";
    kick(0, 0);
    wait_ready("R6 fixed wait", 200, n);
    check("R6 fixed latency", n, FIX + 1);
    kick(2, 0);
    wait_ready("R6 oscillator wait", 1200, n);
    check("R6 oscillator latency", n, OST + 1);

    phase = "R8";
    kick(2, 0);
    repeat (100) @(negedge clk);
    kick(6, 3);
    wait_ready("R8 restart", 1200, n);
    check("R8 restart latency", n, FIX + 1);

    phase = "R9";
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check("R9 stays ready", int'(ready), 1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule